// File: doc/BRIEF.md
# RAM Pointer Register with Bank/Digit Stepping

This block holds the 7-bit data-memory pointer of a small 4-bit processor. The pointer is split into a 3-bit bank field in bits 6:4 and a 4-bit digit field in bits 3:0. The sequencer presents one command per cycle, qualified by a valid strobe, together with the accumulator value, a 2-bit bank operand and a 4-bit digit operand.

Commands can XOR the bank field with the operand, step the digit field up or down, load both fields immediately, move the digit field to or from the accumulator, and swap the bank field with the accumulator. The new pointer appears on the clock edge after the command. A new accumulator value, its write strobe and a skip request for the sequencer appear on that same edge.

Immediate loads have a short form, in which the digit operand holds the target digit minus one, and a long form, in which it holds the digit itself. Once one immediate load has executed, any immediate loads that follow it directly are suppressed and skipped, until some other command arrives. The memory array and the accumulator register sit outside the block.

Top module: `ram_ptr_reg`

## Requirements
- R1: While rst_n is low, and after it is released, ptr_o is 0, skip_o is 0, acc_we_o is 0 and acc_o is 0. Reset also forgets any pending chain of immediate loads, so the first immediate load after reset always executes.
- R2: Op 1 (load-modify) and op 2 (exchange-modify) replace the bank field with bank XOR the zero-extended bank operand. The digit field is unchanged and there is no skip.
- R3: Op 3 (exchange-and-increment) adds 1 to the digit field, with 15 wrapping to 0. It raises skip_o only on that wrap, and it applies the bank XOR of R2.
- R4: Op 4 (exchange-and-decrement) subtracts 1 from the digit field, with 0 wrapping to 15. It raises skip_o only on that wrap, and it applies the bank XOR of R2.
- R5: Op 5 (store-and-advance) adds 1 to the digit field with wrap. It never skips and leaves the bank field unchanged.
- R6: Op 6 (short immediate) treats the digit operand as a code c. When c is 8 to 15, the digit field becomes (c+1) mod 16, so code 15 loads 0. The bank field becomes the zero-extended bank operand. Codes 0 to 7 change nothing and count as a non-load command.
- R7: Op 7 (long immediate) loads the bank field with the zero-extended bank operand and the digit field with the digit operand.
- R8: After an immediate load executes (R6 or R7), every directly following valid immediate load of either form leaves ptr_o unchanged and raises skip_o. The chain ends at the next valid non-load command. Cycles with op_valid_i low neither end it nor extend it.
- R9: Op 8 (accumulator to digit) loads the digit field from acc_i. Op 9 (digit to accumulator) drives acc_o with the digit field and raises acc_we_o.
- R10: Op 10 (swap bank) drives acc_o with the bank field zero-extended, so acc_o bit 3 is 0, and raises acc_we_o. The bank field takes acc_i bits 2:0.
- R11: acc_we_o is high, and acc_o non-zero, only in the cycle after op 9 or op 10. Op 0 and the unused codes 11 to 15 change nothing but end the chain of R8.
- R12: In a cycle with op_valid_i low, ptr_o holds its value, and skip_o and acc_we_o are low on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid_i | input | 1 | Command present this cycle |
| op_i | input | 4 | Command code (see requirements) |
| acc_i | input | 4 | Current accumulator value |
| bank_op_i | input | 2 | Bank operand |
| dig_op_i | input | 4 | Digit operand or short-form code |
| ptr_o | output | 7 | Pointer: bank in 6:4, digit in 3:0 |
| acc_o | output | 4 | New accumulator value |
| acc_we_o | output | 1 | Accumulator write strobe |
| skip_o | output | 1 | Skip request for the next instruction |

## Verification
The embedded properties check the local rules on every cycle: the bank XOR of the modify commands, the wrap and skip of both stepping directions, the absence of skip on store-and-advance, the suppression of a chained long load, the copy of the digit field to the accumulator, and the freeze on idle cycles. Some behaviour depends on history, and only the bench scenarios show it. These are chains of immediate loads broken by idle cycles, an invalid short code, or an ordinary command. They also include a reset in the middle of a chain, the decoding of each short code, and the full swap with the accumulator.

// File: rtl/ram_ptr_pkg.sv
package ram_ptr_pkg;

    parameter int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NONE       = 4'd0,
        OP_LOAD_MOD   = 4'd1,
        OP_EXCH_MOD   = 4'd2,
        OP_EXCH_INC   = 4'd3,
        OP_EXCH_DEC   = 4'd4,
        OP_STORE_ADV  = 4'd5,
        OP_IMM_SHORT  = 4'd6,
        OP_IMM_LONG   = 4'd7,
        OP_ACC_TO_DIG = 4'd8,
        OP_DIG_TO_ACC = 4'd9,
        OP_SWAP_BANK  = 4'd10
    } op_e;

endpackage

// File: rtl/digit_stepper.sv
// Computes both step directions of the digit field and their wrap flags.
module digit_stepper #(
    parameter int DIG_W = 4
) (
    input  logic [DIG_W-1:0] dig_i,
    output logic [DIG_W-1:0] up_o,
    output logic [DIG_W-1:0] dn_o,
    output logic             up_wrap_o,
    output logic             dn_wrap_o
);
    localparam logic [DIG_W-1:0] DIG_MAX = '1;

    always_comb begin
        up_o      = dig_i + 1'b1;
        dn_o      = dig_i - 1'b1;
        up_wrap_o = (dig_i == DIG_MAX);
        dn_wrap_o = (dig_i == '0);
    end
endmodule

// File: rtl/imm_decoder.sv
// Decodes the immediate-load operands. The short form carries digit minus one
// and is legal only when the code MSB is set (target digit 0 or top half + 1).
module imm_decoder #(
    parameter int BANK_W = 3,
    parameter int ROP_W  = 2,
    parameter int DIG_W  = 4
) (
    input  logic              long_i,
    input  logic [DIG_W-1:0]  code_i,
    input  logic [ROP_W-1:0]  bank_op_i,
    output logic              ok_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [DIG_W-1:0]  dig_o
);
    generate
        if (ROP_W < BANK_W) begin : g_zext
            assign bank_o = {{(BANK_W-ROP_W){1'b0}}, bank_op_i};
        end else begin : g_trunc
            assign bank_o = bank_op_i[BANK_W-1:0];
        end
    endgenerate

    always_comb begin
        ok_o  = long_i | code_i[DIG_W-1];
        dig_o = long_i ? code_i : code_i + 1'b1;
    end
endmodule

// File: rtl/ram_ptr_reg.sv
module ram_ptr_reg
    import ram_ptr_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int DIG_W  = 4,
    parameter int ROP_W  = 2,
    parameter int ACC_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    op_valid_i,
    input  logic [OP_W-1:0]         op_i,
    input  logic [ACC_W-1:0]        acc_i,
    input  logic [ROP_W-1:0]        bank_op_i,
    input  logic [DIG_W-1:0]        dig_op_i,
    output logic [BANK_W+DIG_W-1:0] ptr_o,
    output logic [ACC_W-1:0]        acc_o,
    output logic                    acc_we_o,
    output logic                    skip_o
);
    localparam int PTR_W = BANK_W + DIG_W;
    localparam logic [DIG_W-1:0] DIG_MAX = '1;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [DIG_W-1:0]  dig;
        logic [ACC_W-1:0]  acc;
        logic              acc_we;
        logic              skip;
        logic              chain;
    } state_t;

    state_t st_d, st_q;

    logic [DIG_W-1:0]  dig_up, dig_dn;
    logic              up_wrap, dn_wrap;
    logic              imm_ok;
    logic [BANK_W-1:0] imm_bank;
    logic [DIG_W-1:0]  imm_dig;
    logic [ACC_W-1:0]  bank_as_acc;
    op_e               op;

    assign op = op_e'(op_i);

    digit_stepper #(.DIG_W(DIG_W)) u_step (
        .dig_i     (st_q.dig),
        .up_o      (dig_up),
        .dn_o      (dig_dn),
        .up_wrap_o (up_wrap),
        .dn_wrap_o (dn_wrap)
    );

    imm_decoder #(.BANK_W(BANK_W), .ROP_W(ROP_W), .DIG_W(DIG_W)) u_imm (
        .long_i    (op == OP_IMM_LONG),
        .code_i    (dig_op_i),
        .bank_op_i (bank_op_i),
        .ok_o      (imm_ok),
        .bank_o    (imm_bank),
        .dig_o     (imm_dig)
    );

    generate
        if (ACC_W > BANK_W) begin : g_acc_zext
            assign bank_as_acc = {{(ACC_W-BANK_W){1'b0}}, st_q.bank};
        end else begin : g_acc_trunc
            assign bank_as_acc = st_q.bank[ACC_W-1:0];
        end
    endgenerate

    always_comb begin
        st_d        = st_q;
        st_d.acc    = '0;
        st_d.acc_we = 1'b0;
        st_d.skip   = 1'b0;
        if (op_valid_i) begin
            st_d.chain = 1'b0;
            unique case (op)
                OP_LOAD_MOD, OP_EXCH_MOD: begin
                    st_d.bank = st_q.bank ^ imm_bank;
                end
                OP_EXCH_INC: begin
                    st_d.bank = st_q.bank ^ imm_bank;
                    st_d.dig  = dig_up;
                    st_d.skip = up_wrap;
                end
                OP_EXCH_DEC: begin
                    st_d.bank = st_q.bank ^ imm_bank;
                    st_d.dig  = dig_dn;
                    st_d.skip = dn_wrap;
                end
                OP_STORE_ADV: begin
                    st_d.dig = dig_up;
                end
                OP_IMM_SHORT, OP_IMM_LONG: begin
                    if (imm_ok) begin
                        st_d.chain = 1'b1;
                        if (st_q.chain) begin
                            st_d.skip = 1'b1;
                        end else begin
                            st_d.bank = imm_bank;
                            st_d.dig  = imm_dig;
                        end
                    end
                end
                OP_ACC_TO_DIG: begin
                    st_d.dig = acc_i[DIG_W-1:0];
                end
                OP_DIG_TO_ACC: begin
                    st_d.acc    = ACC_W'(st_q.dig);
                    st_d.acc_we = 1'b1;
                end
                OP_SWAP_BANK: begin
                    st_d.acc    = bank_as_acc;
                    st_d.acc_we = 1'b1;
                    st_d.bank   = acc_i[BANK_W-1:0];
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_o    = {st_q.bank, st_q.dig};
    assign acc_o    = st_q.acc;
    assign acc_we_o = st_q.acc_we;
    assign skip_o   = st_q.skip;

    // R2: bank operand is XORed in, digit untouched
    p_bank_xor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_i == OP_LOAD_MOD) |=>
            (ptr_o[PTR_W-1:DIG_W] == ($past(ptr_o[PTR_W-1:DIG_W]) ^ BANK_W'($past(bank_op_i))))
            && (ptr_o[DIG_W-1:0] == $past(ptr_o[DIG_W-1:0])) && !skip_o);

    // R3: increment wraps top digit to zero and skips
    p_inc_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_i == OP_EXCH_INC && ptr_o[DIG_W-1:0] == DIG_MAX) |=>
            (ptr_o[DIG_W-1:0] == '0) && skip_o);

    // R4: decrement wraps zero to top digit and skips
    p_dec_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_i == OP_EXCH_DEC && ptr_o[DIG_W-1:0] == '0) |=>
            (ptr_o[DIG_W-1:0] == DIG_MAX) && skip_o);

    // R5: store-and-advance never skips and keeps the bank
    p_store_noskip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_i == OP_STORE_ADV) |=>
            !skip_o && $stable(ptr_o[PTR_W-1:DIG_W]));

    // R8: a chained long load is suppressed and skipped
    p_chain_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_i == OP_IMM_LONG && st_q.chain) |=>
            $stable(ptr_o) && skip_o);

    // R9: digit copy appears on the accumulator with its strobe
    p_dig_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_i == OP_DIG_TO_ACC) |=>
            acc_we_o && (acc_o == ACC_W'($past(ptr_o[DIG_W-1:0]))));

    // R12: idle cycles freeze the pointer
    p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid_i |=> $stable(ptr_o) && !skip_o && !acc_we_o);

endmodule

// File: tb/ram_ptr_reg_test.sv
module ram_ptr_reg_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid_i = 1'b0;
    logic [3:0] op_i = '0;
    logic [3:0] acc_i = '0;
    logic [1:0] bank_op_i = '0;
    logic [3:0] dig_op_i = '0;
    logic [6:0] ptr_o;
    logic [3:0] acc_o;
    logic       acc_we_o;
    logic       skip_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [6:0] ptr;
        logic [3:0] acc;
        logic       we;
        logic       skip;
        string      tag;
    } exp_t;

    exp_t q[$];

    logic [6:0] m_ptr = '0;
    logic       m_chain = 1'b0;

    always #2 clk = ~clk;

    ram_ptr_reg uut (
        .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_i(op_i),
        .acc_i(acc_i), .bank_op_i(bank_op_i), .dig_op_i(dig_op_i),
        .ptr_o(ptr_o), .acc_o(acc_o), .acc_we_o(acc_we_o), .skip_o(skip_o)
    );

    task automatic check_now(string tag, logic [6:0] p, logic [3:0] a, logic w, logic s);
        checks++;
        if (ptr_o !== p || acc_o !== a || acc_we_o !== w || skip_o !== s) begin
            errors++;
            $display("FAIL %s: got ptr=%h acc=%h we=%b skip=%b, expected ptr=%h acc=%h we=%b skip=%b",
                     tag, ptr_o, acc_o, acc_we_o, skip_o, p, a, w, s);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected outcome.
    task automatic drive(logic v, logic [3:0] op, logic [3:0] acc, logic [1:0] r,
                         logic [3:0] d, string tag);
        exp_t e;
        logic [2:0] bank;
        logic [3:0] dig;
        bank = m_ptr[6:4];
        dig  = m_ptr[3:0];
        e.acc = '0; e.we = 1'b0; e.skip = 1'b0; e.tag = tag;
        @(negedge clk);
        op_valid_i = v; op_i = op; acc_i = acc; bank_op_i = r; dig_op_i = d;
        if (v) begin
            logic was_chain;
            was_chain = m_chain;
            m_chain = 1'b0;
            case (op)
                4'd1, 4'd2: bank = bank ^ {1'b0, r};
                4'd3: begin bank = bank ^ {1'b0, r}; e.skip = (dig == 4'd15); dig = dig + 4'd1; end
                4'd4: begin bank = bank ^ {1'b0, r}; e.skip = (dig == 4'd0); dig = dig - 4'd1; end
                4'd5: dig = dig + 4'd1;
                4'd6, 4'd7: begin
                    if (op == 4'd7 || d >= 4'd8) begin
                        m_chain = 1'b1;
                        if (was_chain) e.skip = 1'b1;
                        else begin
                            bank = {1'b0, r};
                            dig  = (op == 4'd7) ? d : d + 4'd1;
                        end
                    end
                end
                4'd8: dig = acc;
                4'd9: begin e.acc = dig; e.we = 1'b1; end
                4'd10: begin e.acc = {1'b0, bank}; e.we = 1'b1; bank = acc[2:0]; end
                default: ;
            endcase
        end
        m_ptr = {bank, dig};
        e.ptr = m_ptr;
        @(posedge clk);
        #1;
        q.push_back(e);
    endtask

    // Monitor: compares each queued item one half-cycle after it is produced.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check_now(e.tag, e.ptr, e.acc, e.we, e.skip);
        end
    end

    task automatic drain();
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        op_valid_i = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        m_ptr = '0; m_chain = 1'b0;
        check_now("R1 reset held", 7'h00, 4'h0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_now("R1 after reset", 7'h00, 4'h0, 1'b0, 1'b0);
    endtask

    initial begin
        do_reset();
        drive(1, 4'd1, 4'h0, 2'd1, 4'h0, "R2 load-modify bank xor");
        drive(1, 4'd2, 4'h0, 2'd3, 4'h0, "R2 exchange-modify bank xor");
        drive(1, 4'd7, 4'h0, 2'd2, 4'd5, "R7 long immediate");
        drive(1, 4'd6, 4'h0, 2'd1, 4'd8, "R8 chained short skipped");
        drive(1, 4'd7, 4'h0, 2'd1, 4'd3, "R8 chained long skipped");
        drive(0, 4'd7, 4'h0, 2'd0, 4'd0, "R12 idle freeze");
        drive(1, 4'd6, 4'h0, 2'd3, 4'd9, "R8 chain survives idle");
        drive(1, 4'd0, 4'h0, 2'd0, 4'd0, "R11 none ends chain");
        drive(1, 4'd6, 4'h0, 2'd3, 4'd15, "R6 short code 15 loads 0");
        drive(1, 4'd13, 4'h0, 2'd0, 4'd0, "R11 unused code");
        drive(1, 4'd6, 4'h0, 2'd1, 4'd3, "R6 invalid short code ignored");
        drive(1, 4'd6, 4'h0, 2'd0, 4'd10, "R6 short code 10 after invalid");
        drive(1, 4'd8, 4'd14, 2'd0, 4'd0, "R9 acc to digit");
        drive(1, 4'd3, 4'h0, 2'd1, 4'd0, "R3 increment no wrap");
        drive(1, 4'd3, 4'h0, 2'd0, 4'd0, "R3 increment wrap skip");
        drive(1, 4'd4, 4'h0, 2'd2, 4'd0, "R4 decrement wrap skip");
        drive(1, 4'd4, 4'h0, 2'd3, 4'd0, "R4 decrement no wrap");
        drive(1, 4'd8, 4'd15, 2'd0, 4'd0, "R9 acc to digit max");
        drive(1, 4'd5, 4'h0, 2'd3, 4'd0, "R5 store wrap no skip");
        drive(1, 4'd5, 4'h0, 2'd0, 4'd0, "R5 store advance");
        drive(1, 4'd9, 4'h0, 2'd0, 4'd0, "R9 digit to acc");
        drive(1, 4'd10, 4'hD, 2'd0, 4'd0, "R10 swap bank");
        drive(1, 4'd10, 4'h2, 2'd0, 4'd0, "R10 swap bank back");
        drive(1, 4'd4, 4'h0, 2'd0, 4'd0, "R11 no strobe after step");
        for (int i = 8; i < 16; i++) begin
            drive(1, 4'd0, 4'h0, 2'd0, 4'd0, "R11 separator");
            drive(1, 4'd6, 4'h0, 2'(i), 4'(i), "R6 short code sweep");
        end
        drive(1, 4'd7, 4'h0, 2'd2, 4'd6, "R8 long after short skipped");
        drain();
        do_reset();
        drive(1, 4'd7, 4'h0, 2'd3, 4'd7, "R1 load executes after reset");
        drive(1, 4'd7, 4'h0, 2'd1, 4'd1, "R8 chain after reset load");
        drain();
        drive(1, 4'd7, 4'h0, 2'd1, 4'd2, "R1 pre-reset chain start");
        drain();
        do_reset();
        drive(1, 4'd6, 4'h0, 2'd2, 4'd12, "R1 reset cleared chain");
        drain();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule